// File: doc/BRIEF.md
# Translation Cache with Global-Entry Retention

This block is a small, fully associative translation cache for a 32-bit linear address space. It holds recent mappings from virtual page numbers to physical frame numbers. Each entry has its own page size, chosen from 4 KB, 2 MB and 4 MB, and its own global marker. A requester presents a linear address on the lookup port. One cycle later it receives a hit flag and a physical address of up to 36 bits. On a miss, the requester walks the page tables elsewhere and writes the result back through the fill port.

Three mode flags arrive packed in an 8-bit control word:

- The page-size flag permits large pages.
- The wide-address flag selects 2 MB large pages and a 36-bit output, instead of 4 MB large pages and a 32-bit output.
- The global-enable flag decides whether global entries survive a context-switch flush.

A single-entry invalidate removes any entry that covers a given address. Entries are replaced by first taking any free slot and then using a rotating pointer.

Top module: `xlat_cache`

## Requirements
- R1: After reset `lk_done` and `lk_hit` are 0, and every entry is invalid, so any lookup misses.
- R2: A lookup presented with `lk_valid` high produces `lk_done` high exactly one cycle later, together with `lk_hit` and `lk_paddr`. On a miss `lk_paddr` is 0.
- R3: A 4 KB entry matches when linear address bits 31:12 equal its page number. The physical address is `{frame, addr[11:0]}`.
- R4: With page-size flag 1 and wide-address flag 0, a large fill creates a 4 MB entry. It ignores address bits 21:0 when matching and passes them through to the physical address.
- R5: With wide-address flag 1 and page-size flag 1, a large fill creates a 2 MB entry, which ignores and passes through bits 20:0. With the wide-address flag at 1, all 36 output bits are driven from the frame.
- R6: When the wide-address flag is 0 at lookup time, `lk_paddr[35:32]` is 0.
- R7: A large fill made while the page-size flag is 0 creates a 4 KB entry.
- R8: A flush while the global-enable flag is 1 invalidates only entries whose global marker is clear.
- R9: A flush while the global-enable flag is 0 invalidates every entry.
- R10: An invalidate removes every entry whose page-size-masked tag matches `inv_addr`, global entries included.
- R11: A lookup in the same cycle as a flush reports a miss. A fill in the same cycle as a flush is written after the flush and survives it.
- R12: At most one entry matches any lookup. A fill whose masked tag matches a live entry overwrites that entry in place.
- R13: A fill with no matching entry takes the lowest-numbered free slot. When no slot is free, it takes the slot under a rotating pointer that starts at 0 and advances by one on each such eviction.
- R14: The control word uses bit 4 as the page-size flag, bit 5 as the wide-address flag and bit 7 as the global-enable flag. All other bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 8 | Packed mode flags (bits 4, 5, 7) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Linear address to translate |
| fill_valid | input | 1 | Fill request |
| fill_vpn | input | 20 | Virtual page number (address bits 31:12) |
| fill_pfn | input | 24 | Physical frame number (physical bits 35:12) |
| fill_large | input | 1 | Fill is a large page |
| fill_global | input | 1 | Fill is marked global |
| flush | input | 1 | Context-switch flush strobe |
| inv_valid | input | 1 | Single-entry invalidate request |
| inv_addr | input | 32 | Address whose covering entries are removed |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 36 | Translated physical address |

## Verification
The uniqueness property assumes that the requester never fills a large page over a range that already holds a differently sized live entry without that entry being matched. Under that assumption the in-place overwrite keeps the table free of overlaps. The stimulus only creates overlapping ranges through exact duplicate fills, and it fills large pages only in regions where no smaller entry is live. The flush-empties-table property assumes that no fill accompanies the flush, and the bench issues its flush-with-fill case only while global enable is set. The frame numbers used for large pages have their dropped low bits zero, as a page-table walker would deliver them.

// File: rtl/xc_pkg.sv
`timescale 1ns/1ps
package xc_pkg;
  typedef enum logic [1:0] {PG_4K = 2'd0, PG_2M = 2'd1, PG_4M = 2'd2} pg_kind_t;

  localparam int CTRL_PSE_BIT = 4;
  localparam int CTRL_PAE_BIT = 5;
  localparam int CTRL_PGE_BIT = 7;

  localparam int OFF_4K = 12;
  localparam int OFF_2M = 21;
  localparam int OFF_4M = 22;

  function automatic int drop_bits(pg_kind_t k);
    case (k)
      PG_2M:   return OFF_2M - OFF_4K;
      PG_4M:   return OFF_4M - OFF_4K;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/xc_match.sv
`timescale 1ns/1ps
module xc_match
  import xc_pkg::*;
#(
  parameter int VPN_W = 20
) (
  input  logic [VPN_W-1:0] ent_vpn,
  input  pg_kind_t         ent_kind,
  input  logic [VPN_W-1:0] probe_vpn,
  output logic             hit
);
  logic [VPN_W-1:0] keep;
  int               drop;

  always_comb begin
    drop = drop_bits(ent_kind);
    for (int i = 0; i < VPN_W; i++) keep[i] = (i >= drop);
    hit = ((ent_vpn ^ probe_vpn) & keep) == '0;
  end
endmodule

// File: rtl/xc_victim.sv
`timescale 1ns/1ps
module xc_victim #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     free_vec,
  input  logic             evict,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = N-1; i >= 0; i--) begin
      if (free_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
    idx = any_free ? free_idx : rr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (evict) rr_q <= (rr_q == IDX_W'(N-1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache
  import xc_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int VA_W      = 32,
  parameter int PA_W      = 36,
  parameter int NARROW_W  = 32,
  localparam int VPN_W    = VA_W - OFF_4K,
  localparam int PFN_W    = PA_W - OFF_4K,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [7:0]      ctrl,
  input  logic            lk_valid,
  input  logic [VA_W-1:0] lk_addr,
  input  logic            fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic            fill_large,
  input  logic            fill_global,
  input  logic            flush,
  input  logic            inv_valid,
  input  logic [VA_W-1:0] inv_addr,
  output logic            lk_done,
  output logic            lk_hit,
  output logic [PA_W-1:0] lk_paddr
);
  logic pse, pae, pge;
  assign pse = ctrl[CTRL_PSE_BIT];
  assign pae = ctrl[CTRL_PAE_BIT];
  assign pge = ctrl[CTRL_PGE_BIT];

  logic [VPN_W-1:0] vpn_q  [N_ENTRIES];
  logic [PFN_W-1:0] pfn_q  [N_ENTRIES];
  pg_kind_t         kind_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] glob_q;
  logic [N_ENTRIES-1:0] valid_q;

  logic [N_ENTRIES-1:0] lk_match, fill_match, inv_match;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    xc_match #(.VPN_W(VPN_W)) u_lk (
      .ent_vpn(vpn_q[e]), .ent_kind(kind_q[e]),
      .probe_vpn(lk_addr[VA_W-1:OFF_4K]), .hit(lk_match[e]));
    xc_match #(.VPN_W(VPN_W)) u_fl (
      .ent_vpn(vpn_q[e]), .ent_kind(kind_q[e]),
      .probe_vpn(fill_vpn), .hit(fill_match[e]));
    xc_match #(.VPN_W(VPN_W)) u_iv (
      .ent_vpn(vpn_q[e]), .ent_kind(kind_q[e]),
      .probe_vpn(inv_addr[VA_W-1:OFF_4K]), .hit(inv_match[e]));
  end

  function automatic logic [IDX_W-1:0] low_idx(logic [N_ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_ENTRIES-1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  // Update side: flush, then invalidate, then fill.
  logic [N_ENTRIES-1:0] flush_kill, inv_kill, survive, dup_vec, free_vec;
  logic [N_ENTRIES-1:0] fill_onehot;
  logic [IDX_W-1:0]     vic_idx, tgt_idx;
  logic                 has_dup, evict;
  pg_kind_t             fill_kind;

  always_comb begin
    flush_kill = flush ? (pge ? ~glob_q : '1) : '0;
    inv_kill   = inv_valid ? inv_match : '0;
    survive    = valid_q & ~flush_kill & ~inv_kill;
    dup_vec    = survive & fill_match;
    has_dup    = |dup_vec;
    free_vec   = ~survive;
    tgt_idx    = has_dup ? low_idx(dup_vec) : vic_idx;
    evict      = fill_valid && !has_dup && (free_vec == '0);
    fill_onehot = '0;
    if (fill_valid) fill_onehot[tgt_idx] = 1'b1;
    if (fill_large && pse) fill_kind = pae ? PG_2M : PG_4M;
    else                   fill_kind = PG_4K;
  end

  xc_victim #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_vic (
    .clk(clk), .rst(rst), .free_vec(free_vec), .evict(evict), .idx(vic_idx));

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= survive | fill_onehot;
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      vpn_q[tgt_idx]  <= fill_vpn;
      pfn_q[tgt_idx]  <= fill_pfn;
      kind_q[tgt_idx] <= fill_kind;
      glob_q[tgt_idx] <= fill_global;
    end
  end

  // Lookup side.
  logic [N_ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]     sel;
  logic [PA_W-1:0]      pa_c;
  int                   off;

  always_comb begin
    hit_vec = valid_q & lk_match;
    sel     = low_idx(hit_vec);
    off     = OFF_4K + drop_bits(kind_q[sel]);
    pa_c    = {pfn_q[sel], {OFF_4K{1'b0}}};
    for (int i = 0; i < OFF_4M; i++) if (i < off) pa_c[i] = lk_addr[i];
    if (!pae) pa_c[PA_W-1:NARROW_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done  <= 1'b0;
      lk_hit   <= 1'b0;
      lk_paddr <= '0;
    end else begin
      lk_done <= lk_valid;
      if (lk_valid && (hit_vec != '0) && !flush) begin
        lk_hit   <= 1'b1;
        lk_paddr <= pa_c;
      end else begin
        lk_hit   <= 1'b0;
        lk_paddr <= '0;
      end
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
`timescale 1ns/1ps
module xlat_cache_chk #(
  parameter int N    = 16,
  parameter int VA_W = 32,
  parameter int PA_W = 36
) (
  input logic            clk,
  input logic            rst,
  input logic [7:0]      ctrl,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_addr,
  input logic            flush,
  input logic            fill_valid,
  input logic            lk_done,
  input logic            lk_hit,
  input logic [PA_W-1:0] lk_paddr,
  input logic [N-1:0]    hit_vec,
  input logic [N-1:0]    valid_q
);
  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> lk_done);

  // R2
  hit_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_done);

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (!lk_hit || lk_paddr[11:0] == $past(lk_addr[11:0])));

  // R6
  narrow_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !ctrl[5]) |=> lk_paddr[PA_W-1:32] == '0);

  // R9
  flush_all_chk: assert property (@(posedge clk) disable iff (rst)
    (flush && !ctrl[7] && !fill_valid) |=> valid_q == '0);

  // R11
  flush_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && flush) |=> !lk_hit);

  // R12
  unique_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

bind xlat_cache xlat_cache_chk #(.N(N_ENTRIES), .VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .flush(flush), .fill_valid(fill_valid), .lk_done(lk_done), .lk_hit(lk_hit),
  .lk_paddr(lk_paddr), .hit_vec(hit_vec), .valid_q(valid_q));

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ctrl = 8'h90;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [23:0] fill_pfn = '0;
  logic        fill_large = 1'b0;
  logic        fill_global = 1'b0;
  logic        flush = 1'b0;
  logic        inv_valid = 1'b0;
  logic [31:0] inv_addr = '0;
  logic        lk_done, lk_hit;
  logic [35:0] lk_paddr;

  always #5 clk = ~clk;

  xlat_cache u0 (
    .clk(clk), .rst(rst), .ctrl(ctrl), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_large(fill_large), .fill_global(fill_global), .flush(flush),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_paddr(lk_paddr));

  typedef struct {
    logic        hit;
    logic [35:0] pa;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   finished = 1'b0;

  // Monitor: pops one expectation per completed lookup.
  always @(negedge clk) begin
    if (!rst && lk_done) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2: unexpected lk_done, act hit=%0b pa=%h exp none", lk_hit, lk_paddr);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (lk_hit !== e.hit || lk_paddr !== e.pa) begin
          n_fail++;
          $display("FAIL %s: act hit=%0b pa=%h exp hit=%0b pa=%h",
                   e.tag, lk_hit, lk_paddr, e.hit, e.pa);
        end
      end
    end
  end

  task automatic lookup(input logic [31:0] a, input logic eh,
                        input logic [35:0] epa, input string tag);
    exp_t e;
    e.hit = eh; e.pa = epa; e.tag = tag;
    exp_q.push_back(e);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [23:0] p,
                      input logic lg, input logic gl);
    fill_valid = 1'b1; fill_vpn = v; fill_pfn = p;
    fill_large = lg; fill_global = gl;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic do_inv(input logic [31:0] a);
    inv_valid = 1'b1; inv_addr = a;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    n_tests++;
    if (lk_done !== 1'b0 || lk_hit !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: act done=%0b hit=%0b exp 0 0", lk_done, lk_hit);
    end
    lookup(32'h1234_5678, 1'b0, 36'h0, "R1");

    // R3 / R6: 4 KB entry, upper nibble masked with wide-address off
    fill(20'h12345, 24'h3F0ABC, 1'b0, 1'b0);
    lookup(32'h1234_5678, 1'b1, 36'h0F0ABC678, "R3_R6");

    // R4 / R14: 4 MB with extra control bits set (0x9F)
    ctrl = 8'h9F;
    fill(20'h80000, 24'h001400, 1'b1, 1'b0);
    lookup(32'h803F_F123, 1'b1, 36'h0017FF123, "R4_R14");
    lookup(32'h8040_0000, 1'b0, 36'h0, "R4");
    ctrl = 8'h90;

    // R8: global entry survives flush with global enable set
    fill(20'h00001, 24'h000055, 1'b0, 1'b1);
    do_flush();
    lookup(32'h0000_1ABC, 1'b1, 36'h000055ABC, "R8");
    lookup(32'h1234_5678, 1'b0, 36'h0, "R8");
    lookup(32'h803F_F123, 1'b0, 36'h0, "R8");

    // R9: flush with global enable clear removes everything
    ctrl = 8'h10;
    do_flush();
    lookup(32'h0000_1ABC, 1'b0, 36'h0, "R9");

    // R5: 2 MB entry and 36-bit output with wide-address on
    ctrl = 8'hB0;
    fill(20'h40000, 24'hABC200, 1'b1, 1'b0);
    lookup(32'h401F_FFF0, 1'b1, 36'hABC3FFFF0, "R5");
    lookup(32'h4020_0000, 1'b0, 36'h0, "R5");
    fill(20'h00002, 24'hF00001, 1'b0, 1'b0);
    lookup(32'h0000_2004, 1'b1, 36'hF00001004, "R5");

    // R7: large fill with page-size flag off is 4 KB
    ctrl = 8'h80;
    fill(20'h60000, 24'h000777, 1'b1, 1'b0);
    lookup(32'h6000_0010, 1'b1, 36'h000777010, "R7");
    lookup(32'h6000_1010, 1'b0, 36'h0, "R7");

    // R10: invalidate removes a global entry, others stay
    fill(20'h00003, 24'h000033, 1'b0, 1'b1);
    lookup(32'h0000_3000, 1'b1, 36'h000033000, "R10");
    do_inv(32'h0000_3FFF);
    lookup(32'h0000_3000, 1'b0, 36'h0, "R10");
    lookup(32'h6000_0010, 1'b1, 36'h000777010, "R10");

    // R11: lookup during flush misses
    begin
      exp_t e;
      e.hit = 1'b0; e.pa = 36'h0; e.tag = "R11";
      exp_q.push_back(e);
      lk_valid = 1'b1; lk_addr = 32'h6000_0010; flush = 1'b1;
      @(negedge clk);
      lk_valid = 1'b0; flush = 1'b0;
    end
    // R11: fill together with flush survives
    fill_valid = 1'b1; fill_vpn = 20'h70000; fill_pfn = 24'h000001;
    fill_large = 1'b0; fill_global = 1'b0; flush = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0; flush = 1'b0;
    lookup(32'h7000_0123, 1'b1, 36'h000001123, "R11");

    // R12: duplicate fill overwrites in place
    fill(20'h70000, 24'h000002, 1'b0, 1'b0);
    lookup(32'h7000_0123, 1'b1, 36'h000002123, "R12");

    // R13: free slots first, then rotating eviction
    ctrl = 8'h10;
    do_flush();
    ctrl = 8'h90;
    for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 24'h000100 + 24'(i), 1'b0, 1'b0);
    lookup(32'h0010_F004, 1'b1, 36'h00010F004, "R13");
    fill(20'h00200, 24'h000200, 1'b0, 1'b0);
    lookup(32'h0010_0000, 1'b0, 36'h0, "R13");
    lookup(32'h0010_1000, 1'b1, 36'h000101000, "R13");
    lookup(32'h0020_0000, 1'b1, 36'h000200000, "R13");
    fill(20'h00201, 24'h000201, 1'b0, 1'b0);
    lookup(32'h0010_1000, 1'b0, 36'h0, "R13");
    do_inv(32'h0010_5000);
    fill(20'h00202, 24'h000202, 1'b0, 1'b0);
    lookup(32'h0010_2000, 1'b1, 36'h000102000, "R13");
    fill(20'h00203, 24'h000203, 1'b0, 1'b0);
    lookup(32'h0010_2000, 1'b0, 36'h0, "R13");
    lookup(32'h0010_3000, 1'b1, 36'h000103000, "R13");
    lookup(32'h0020_2000, 1'b1, 36'h000202000, "R13");

    repeat (3) @(negedge clk);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: act %0d results missing exp 0", exp_q.size());
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule